// File: doc/BRIEF.md
# Host Command to Memory Port Bridge

This block sits between a serial host link and the user port of a FIFO-based memory controller. The host delivers 64-bit command words. Each word carries an operation flag, a 26-bit word address and 32 bits of write data. The block turns each word into one single-word transaction on the controller port. That port has three parts: a command channel, a write-data FIFO and a read-data FIFO.

A write command first pushes the data word into the write FIFO. It then issues the write command in a later cycle. A read command issues the read, waits until the read FIFO holds a word, pops that word and returns it to the host with a one-cycle strobe.

The block handles one transaction at a time. It accepts a new command only while it reports itself not busy, and it stays busy until the controller reports calibration done. The controller expects byte addresses, so the word address is shifted up by two bits. The burst field carries the word count minus one, and the byte mask enables all four bytes.

Top module: `host_mem_bridge`

## Requirements
- R1: During and right after reset, mem_wr_en, mem_cmd_en, mem_rd_en and rd_valid are low and rd_word is zero.
- R2: While calib_done is low, host_busy is high and host_valid causes no memory port activity.
- R3: A host word presented while host_busy is high is ignored: it produces no memory port activity and does not change memory contents.
- R4: Bit 63 of host_word selects the operation (0 write, 1 read). Bits 62..37 hold the word address and bits 31..0 hold the write data. Bits 36..32 have no effect.
- R5: mem_cmd_addr is the byte address {2'b00, word_address, 2'b00}. mem_cmd_instr is 3'b000 for a write and 3'b001 for a read. mem_cmd_bl is 0 and mem_wr_mask is 4'b0000.
- R6: For a write, mem_wr_en is high for exactly one handshake cycle carrying the write data. mem_cmd_en for that write comes in a strictly later cycle, never in the same cycle.
- R7: mem_wr_en is never high while mem_wr_full is high, and mem_cmd_en is never high while mem_cmd_full is high. The block waits out either condition.
- R8: For a read, after the command is issued, mem_rd_en is asserted once, and only in a cycle where mem_rd_empty is low.
- R9: rd_valid pulses high for exactly one cycle, one cycle after the pop. rd_word then carries the popped word and holds it until the next read returns.
- R10: host_busy rises in the cycle after a command is accepted. It falls in the cycle after the write command handshake, or in the cycle rd_valid is high for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| calib_done | input | 1 | Memory controller calibration complete |
| host_valid | input | 1 | Host command word present |
| host_word | input | 64 | Packed host command word |
| host_busy | output | 1 | High while a command cannot be accepted |
| rd_valid | output | 1 | One-cycle strobe: read data returned |
| rd_word | output | 32 | Last returned read data |
| mem_cmd_en | output | 1 | Command channel strobe |
| mem_cmd_instr | output | 3 | Command code |
| mem_cmd_addr | output | 30 | Byte address |
| mem_cmd_bl | output | 6 | Burst length minus one |
| mem_cmd_full | input | 1 | Command FIFO full |
| mem_wr_en | output | 1 | Write-data FIFO push |
| mem_wr_data | output | 32 | Write data |
| mem_wr_mask | output | 4 | Byte mask, 1 disables a byte |
| mem_wr_full | input | 1 | Write-data FIFO full |
| mem_rd_en | output | 1 | Read-data FIFO pop |
| mem_rd_data | input | 32 | Read-data FIFO head |
| mem_rd_empty | input | 1 | Read-data FIFO empty |

## Verification
The hardest state to reach is a host word arriving while a read is still waiting on an empty read FIFO, together with FIFO-full conditions that hold across several cycles. The bench model of the controller can force a long read latency and can hold both full flags high. Under those conditions it drives stray host words and checks that none of them reaches memory. It also issues writes to neighbouring word addresses and reads them back, so a dropped or merged address bit shows up as returned data that does not match.

// File: rtl/hmb_pkg.sv
// Shared codes and state type for the host-to-memory-port bridge.
package hmb_pkg;
    localparam logic [2:0] PORT_OP_WRITE = 3'b000;
    localparam logic [2:0] PORT_OP_READ  = 3'b001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WPUSH,
        ST_WCMD,
        ST_RCMD,
        ST_RWAIT
    } seq_state_t;
endpackage

// File: rtl/hmb_decode.sv
// Splits a packed host word into operation, byte address and write data.
// Assumes the address field sits just below the operation bit and that
// the port address has at least as many bits as word address plus offset.
module hmb_decode #(
    parameter int HOST_W      = 64,
    parameter int WADDR_W     = 26,
    parameter int DATA_W      = 32,
    parameter int ADDR_LSB    = 37,
    parameter int PORT_ADDR_W = 30
) (
    input  logic [HOST_W-1:0]      host_word,
    output logic                   is_read,
    output logic [PORT_ADDR_W-1:0] byte_addr,
    output logic [DATA_W-1:0]      wr_data
);
    localparam int OFS_W = $clog2(DATA_W / 8);
    localparam int PAD_W = PORT_ADDR_W - WADDR_W - OFS_W;

    logic [WADDR_W-1:0] word_addr;
    logic               spare_unused;

    // field extraction
    assign is_read      = host_word[HOST_W-1];
    assign word_addr    = host_word[ADDR_LSB +: WADDR_W];
    assign wr_data      = host_word[DATA_W-1:0];
    assign spare_unused = ^host_word[ADDR_LSB-1:DATA_W];

    // byte address: word address shifted past the byte offset, zero padded
    generate
        if (PAD_W > 0) begin : g_pad
            assign byte_addr = {{PAD_W{1'b0}}, word_addr, {OFS_W{1'b0}}};
        end else begin : g_nopad
            assign byte_addr = {word_addr, {OFS_W{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/hmb_seq.sv
// Transaction sequencer: accepts one decoded command when idle and
// calibrated, then walks the write (push, then command) or read
// (command, then pop) handshake. Strobes are gated by the FIFO flags.
module hmb_seq
    import hmb_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int PORT_ADDR_W = 30
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   calib_done,
    input  logic                   host_valid,
    input  logic                   dec_is_read,
    input  logic [PORT_ADDR_W-1:0] dec_addr,
    input  logic [DATA_W-1:0]      dec_data,
    input  logic                   cmd_full,
    input  logic                   wr_full,
    input  logic                   rd_empty,
    output logic                   busy,
    output logic                   cmd_en,
    output logic [2:0]             cmd_instr,
    output logic [PORT_ADDR_W-1:0] cmd_addr,
    output logic                   wr_en,
    output logic [DATA_W-1:0]      wr_data,
    output logic                   rd_take
);
    seq_state_t             state_q, state_d;
    logic [PORT_ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0]      data_q;
    logic                   accept;

    assign busy   = !calib_done || (state_q != ST_IDLE);
    assign accept = host_valid && !busy;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = dec_is_read ? ST_RCMD : ST_WPUSH;
            ST_WPUSH: if (!wr_full) state_d = ST_WCMD;
            ST_WCMD:  if (!cmd_full) state_d = ST_IDLE;
            ST_RCMD:  if (!cmd_full) state_d = ST_RWAIT;
            ST_RWAIT: if (!rd_empty) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // command capture on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (accept) begin
            addr_q <= dec_addr;
            data_q <= dec_data;
        end
    end

    // handshake strobes, held off while the matching FIFO flag blocks
    assign wr_en     = (state_q == ST_WPUSH) && !wr_full;
    assign cmd_en    = ((state_q == ST_WCMD) || (state_q == ST_RCMD)) && !cmd_full;
    assign rd_take   = (state_q == ST_RWAIT) && !rd_empty;
    assign cmd_instr = (state_q == ST_RCMD) ? PORT_OP_READ : PORT_OP_WRITE;
    assign cmd_addr  = addr_q;
    assign wr_data   = data_q;
endmodule

// File: rtl/hmb_rdret.sv
// Read return stage: registers the popped word and raises a one-cycle
// valid strobe in the cycle after the pop.
module hmb_rdret #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              valid,
    output logic [DATA_W-1:0] word
);
    // strobe and data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            word  <= '0;
        end else begin
            valid <= take;
            if (take) word <= fifo_data;
        end
    end
endmodule

// File: rtl/host_mem_bridge.sv
// Top of the bridge: decode, sequencer and read return. Single-word
// accesses only: burst field fixed at zero, all bytes enabled.
module host_mem_bridge #(
    parameter int HOST_W      = 64,
    parameter int WADDR_W     = 26,
    parameter int DATA_W      = 32,
    parameter int ADDR_LSB    = 37,
    parameter int PORT_ADDR_W = 30,
    parameter int BL_W        = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   calib_done,
    input  logic                   host_valid,
    input  logic [HOST_W-1:0]      host_word,
    output logic                   host_busy,
    output logic                   rd_valid,
    output logic [DATA_W-1:0]      rd_word,
    output logic                   mem_cmd_en,
    output logic [2:0]             mem_cmd_instr,
    output logic [PORT_ADDR_W-1:0] mem_cmd_addr,
    output logic [BL_W-1:0]        mem_cmd_bl,
    input  logic                   mem_cmd_full,
    output logic                   mem_wr_en,
    output logic [DATA_W-1:0]      mem_wr_data,
    output logic [DATA_W/8-1:0]    mem_wr_mask,
    input  logic                   mem_wr_full,
    output logic                   mem_rd_en,
    input  logic [DATA_W-1:0]      mem_rd_data,
    input  logic                   mem_rd_empty
);
    localparam int MASK_W = DATA_W / 8;

    logic                   dec_is_read;
    logic [PORT_ADDR_W-1:0] dec_addr;
    logic [DATA_W-1:0]      dec_data;
    logic                   rd_take;

    hmb_decode #(
        .HOST_W(HOST_W), .WADDR_W(WADDR_W), .DATA_W(DATA_W),
        .ADDR_LSB(ADDR_LSB), .PORT_ADDR_W(PORT_ADDR_W)
    ) u_dec (
        .host_word (host_word),
        .is_read   (dec_is_read),
        .byte_addr (dec_addr),
        .wr_data   (dec_data)
    );

    hmb_seq #(.DATA_W(DATA_W), .PORT_ADDR_W(PORT_ADDR_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .calib_done  (calib_done),
        .host_valid  (host_valid),
        .dec_is_read (dec_is_read),
        .dec_addr    (dec_addr),
        .dec_data    (dec_data),
        .cmd_full    (mem_cmd_full),
        .wr_full     (mem_wr_full),
        .rd_empty    (mem_rd_empty),
        .busy        (host_busy),
        .cmd_en      (mem_cmd_en),
        .cmd_instr   (mem_cmd_instr),
        .cmd_addr    (mem_cmd_addr),
        .wr_en       (mem_wr_en),
        .wr_data     (mem_wr_data),
        .rd_take     (rd_take)
    );

    hmb_rdret #(.DATA_W(DATA_W)) u_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (rd_take),
        .fifo_data (mem_rd_data),
        .valid     (rd_valid),
        .word      (rd_word)
    );

    // single-word access, every byte written
    assign mem_rd_en   = rd_take;
    assign mem_cmd_bl  = '0;
    assign mem_wr_mask = {MASK_W{1'b0}};
endmodule

// File: rtl/hmb_checks.sv
// Protocol checker for host_mem_bridge, attached by bind below.
module hmb_checks #(
    parameter int PORT_ADDR_W = 30,
    parameter int BL_W        = 6,
    parameter int MASK_W      = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   calib_done,
    input logic                   host_busy,
    input logic                   rd_valid,
    input logic                   mem_cmd_en,
    input logic [2:0]             mem_cmd_instr,
    input logic [PORT_ADDR_W-1:0] mem_cmd_addr,
    input logic [BL_W-1:0]        mem_cmd_bl,
    input logic                   mem_cmd_full,
    input logic                   mem_wr_en,
    input logic [MASK_W-1:0]      mem_wr_mask,
    input logic                   mem_wr_full,
    input logic                   mem_rd_en,
    input logic                   mem_rd_empty
);
    logic push_seen;

    // tracks a write-data push that has not yet been followed by its command
    always_ff @(posedge clk) begin
        if (!rst_n) push_seen <= 1'b0;
        else if (mem_cmd_en && mem_cmd_instr == 3'b000) push_seen <= 1'b0;
        else if (mem_wr_en) push_seen <= 1'b1;
    end

    a_r2_uncal_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !calib_done |-> host_busy);
    a_r5_single_word: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_en |-> (mem_cmd_bl == '0 && mem_wr_mask == '0 && mem_cmd_addr[1:0] == 2'b00));
    a_r6_push_before_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd_en && mem_cmd_instr == 3'b000) |-> (push_seen && !mem_wr_en));
    a_r7_wr_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> !mem_wr_full);
    a_r7_cmd_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_en |-> !mem_cmd_full);
    a_r8_pop_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !mem_rd_empty);
    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    a_r9_valid_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(mem_rd_en));
endmodule

bind host_mem_bridge hmb_checks #(
    .PORT_ADDR_W(PORT_ADDR_W), .BL_W(BL_W), .MASK_W(DATA_W/8)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .calib_done    (calib_done),
    .host_busy     (host_busy),
    .rd_valid      (rd_valid),
    .mem_cmd_en    (mem_cmd_en),
    .mem_cmd_instr (mem_cmd_instr),
    .mem_cmd_addr  (mem_cmd_addr),
    .mem_cmd_bl    (mem_cmd_bl),
    .mem_cmd_full  (mem_cmd_full),
    .mem_wr_en     (mem_wr_en),
    .mem_wr_mask   (mem_wr_mask),
    .mem_wr_full   (mem_wr_full),
    .mem_rd_en     (mem_rd_en),
    .mem_rd_empty  (mem_rd_empty)
);

// File: tb/tb_host_mem_bridge.sv
`timescale 1ns/1ps
module tb_host_mem_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        calib_done = 1'b0;
    logic        host_valid = 1'b0;
    logic [63:0] host_word = '0;
    logic        host_busy, rd_valid;
    logic [31:0] rd_word;
    logic        mem_cmd_en;
    logic [2:0]  mem_cmd_instr;
    logic [29:0] mem_cmd_addr;
    logic [5:0]  mem_cmd_bl;
    logic        mem_cmd_full = 1'b0;
    logic        mem_wr_en;
    logic [31:0] mem_wr_data;
    logic [3:0]  mem_wr_mask;
    logic        mem_wr_full = 1'b0;
    logic        mem_rd_en;
    logic [31:0] mem_rd_data = '0;
    logic        mem_rd_empty = 1'b1;

    host_mem_bridge dut (.*);

    always #2.5 clk = ~clk;

    int unsigned vectors = 0, fails = 0;
    // expectation for the command in flight
    logic        exp_rd = 1'b0;
    logic [25:0] exp_addr = '0;
    logic [31:0] exp_data = '0;
    // controller model state
    logic [31:0] mm  [logic [25:0]];
    logic [31:0] ref_mem [logic [25:0]];
    int          push_cnt = 0, ev_cnt = 0, cmd_cnt = 0;
    bit          cmd_seen = 0, got = 0, prev_valid = 0;
    bit          rd_pend = 0, rd_avail = 0, hold_rd = 0, stall_all = 0;
    int          rd_delay = 0;
    logic [31:0] rd_val = '0;
    logic [31:0] wr_hold = '0;

    function automatic logic [31:0] dflt(input logic [25:0] a);
        return {6'h2A, a};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // controller model: drive flags at negedge, observe strobes just after
    always @(negedge clk) begin
        if (rst_n) begin
            mem_cmd_full = stall_all || ($urandom % 4 == 0);
            mem_wr_full  = stall_all || ($urandom % 4 == 0);
            if (rd_pend) begin
                if (rd_delay == 0) begin rd_avail = 1; rd_pend = 0; end
                else rd_delay--;
            end
            mem_rd_empty = !rd_avail;
            mem_rd_data  = rd_avail ? rd_val : $urandom;
        end
        #1;
        if (mem_cmd_en) begin
            ev_cnt++; cmd_cnt++; cmd_seen = 1;
            chk(!mem_cmd_full, "R7 cmd while full", 64'(mem_cmd_full), 0);
            chk(mem_cmd_addr == {2'b00, exp_addr, 2'b00}, "R5 byte address", 64'(mem_cmd_addr), 64'({2'b00, exp_addr, 2'b00}));
            chk(mem_cmd_bl == 0 && mem_wr_mask == 0, "R5 burst/mask", 64'({mem_cmd_bl, mem_wr_mask}), 0);
            chk(mem_cmd_instr == (exp_rd ? 3'b001 : 3'b000), "R4 opcode", 64'(mem_cmd_instr), 64'(exp_rd));
            if (mem_cmd_instr == 3'b000) begin
                chk(push_cnt == 1, "R6 one earlier push", 64'(push_cnt), 1);
                mm[mem_cmd_addr[27:2]] = wr_hold;
                push_cnt = 0;
            end else begin
                rd_pend  = 1;
                rd_delay = hold_rd ? 25 : int'($urandom % 6);
                rd_val   = mm.exists(mem_cmd_addr[27:2]) ? mm[mem_cmd_addr[27:2]] : dflt(mem_cmd_addr[27:2]);
            end
        end
        if (mem_wr_en) begin
            ev_cnt++; push_cnt++; wr_hold = mem_wr_data;
            chk(!mem_wr_full, "R7 push while full", 64'(mem_wr_full), 0);
            chk(!exp_rd && mem_wr_data == exp_data, "R4 write data", 64'(mem_wr_data), 64'(exp_data));
        end
        if (mem_rd_en) begin
            ev_cnt++;
            chk(rd_avail, "R8 pop while empty", 0, 1);
            rd_avail = 0;
        end
        if (rd_valid) begin
            got = 1;
            chk(!prev_valid, "R9 single-cycle strobe", 1, 0);
            chk(rd_word == exp_data, "R9 read word", 64'(rd_word), 64'(exp_data));
        end
        prev_valid = rd_valid;
    end

    task automatic do_cmd(input bit is_rd, input logic [25:0] a, input logic [31:0] d);
        int waited = 0;
        exp_rd   = is_rd;
        exp_addr = a;
        exp_data = is_rd ? (ref_mem.exists(a) ? ref_mem[a] : dflt(a)) : d;
        cmd_seen = 0; got = 0;
        @(negedge clk);
        host_word  = {is_rd, a, 5'($urandom), d};
        host_valid = 1'b1;
        @(negedge clk);
        host_valid = 1'b0;
        #2;
        chk(host_busy, "R10 busy after accept", 64'(host_busy), 1);
        while (host_busy && waited < 1000) begin
            @(negedge clk); #2; waited++;
        end
        chk(is_rd ? got : cmd_seen, "R10 busy released after completion", 0, 1);
        if (!is_rd) ref_mem[a] = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        #2;
        chk(!mem_wr_en && !mem_cmd_en && !mem_rd_en && !rd_valid && rd_word == 0, "R1 reset outputs", 64'({mem_wr_en, mem_cmd_en, mem_rd_en, rd_valid}), 0);
        @(negedge clk); rst_n = 1'b1;
        // R2: uncalibrated, host words ignored
        exp_rd = 1'b1;
        host_word = {1'b0, 26'h15, 5'h0, 32'h1111_2222};
        host_valid = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); #2;
            chk(host_busy, "R2 busy while uncalibrated", 64'(host_busy), 1);
        end
        host_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(ev_cnt == 0, "R2 no port activity", 64'(ev_cnt), 0);
        chk(!rd_valid && rd_word == 0, "R1 outputs idle after reset", 64'(rd_word), 0);
        calib_done = 1'b1;
        @(negedge clk); #2;
        chk(!host_busy, "R2 ready after calibration", 64'(host_busy), 0);
        // neighbouring words must not alias
        do_cmd(0, 26'd0, 32'hA0A0_0000);
        do_cmd(0, 26'd1, 32'hB1B1_1111);
        do_cmd(1, 26'd0, 0);
        do_cmd(1, 26'd1, 0);
        do_cmd(0, 26'h3FF_FFFF, 32'hFFFF_0001);
        do_cmd(1, 26'h3FF_FFFF, 0);
        do_cmd(1, 26'h200_0000, 0);
        // R3: stray words during a long read wait are ignored
        hold_rd = 1;
        fork
            begin
                repeat (4) @(negedge clk);
                host_word = {1'b0, 26'd7, 5'h1F, 32'hDEAD_0007};
                host_valid = 1'b1;
                repeat (3) @(negedge clk);
                host_valid = 1'b0;
            end
        join_none
        base = cmd_cnt;
        do_cmd(1, 26'd2, 0);
        hold_rd = 0;
        chk(cmd_cnt - base == 1, "R3 stray word issued nothing", 64'(cmd_cnt - base), 1);
        do_cmd(1, 26'd7, 0);
        // R7: both FIFOs full for a stretch
        stall_all = 1;
        fork begin repeat (10) @(negedge clk); stall_all = 0; end join_none
        base = ev_cnt;
        do_cmd(0, 26'd9, 32'h0909_0909);
        chk(ev_cnt - base == 2, "R7 write completed after stall", 64'(ev_cnt - base), 2);
        do_cmd(1, 26'd9, 0);
        // random mix over a small address set with varied high bits
        for (int n = 0; n < 300; n++) begin
            logic [25:0] a;
            a = {($urandom % 3 == 0) ? 22'($urandom) : 22'd0, 4'($urandom)};
            do_cmd($urandom % 2, a, $urandom);
        end
        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule